// File: doc/BRIEF.md
# Phase-Split Two-Read One-Write Memory

This block turns a single storage array into a memory that serves two reads and one write in every system cycle. Each system cycle spans two periods of the block's clock. The first period is the read phase, in which the array serves both read ports together. The second period is the write phase, in which the array takes at most one update. No storage cell ever needs more than one write path.

A client presents both read addresses and the write request during the read phase. The block samples all of them at the clock edge that closes the read phase. Read data is registered at that same edge and holds through the write phase. The write request is held in a staging register and committed to the array at the edge that closes the write phase.

Because the read phase comes first, a read and a write to the same word in the same system cycle return the word's old contents. The new value appears on the next system cycle. A `read_phase` output tells the client which phase the current clock period belongs to.

Top module: `phased_2r1w_mem`

## Requirements
- R1: After synchronous reset every word of the array holds zero, both read outputs are zero, and the first clock period after reset is a read phase (`read_phase` = 1).
- R2: `read_phase` alternates on every clock period: 1 (read phase), then 0 (write phase), and so on.
- R3: At the edge that closes a read phase, `rd_data_a` and `rd_data_b` take the contents of the words at `rd_addr_a` and `rd_addr_b`. The two addresses are independent and may differ.
- R4: Both read outputs keep their value across the edge that closes the write phase, so each value is steady for a full system cycle.
- R5: A write with `wr_en` = 1 sampled at the close of a read phase stores `wr_data` at `wr_addr` at the close of the following write phase. Reads in later system cycles return it.
- R6: A read of the word that the same system cycle writes returns the contents from before the write.
- R7: When `wr_en` = 0 is sampled, the write phase changes no word of the array.
- R8: Address, data and enable inputs are sampled only at the edge that closes the read phase. Values driven during the write phase have no effect on that system cycle.
- R9: Both read ports addressing the same word in one system cycle return identical data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; two periods form one system cycle |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | AW | Word address for read port A |
| rd_addr_b | input | AW | Word address for read port B |
| wr_addr | input | AW | Word address for the write port |
| wr_data | input | DW | Data to be written |
| wr_en | input | 1 | Write request for this system cycle |
| rd_data_a | output | DW | Registered read data, port A |
| rd_data_b | output | DW | Registered read data, port B |
| read_phase | output | 1 | High during the read phase of each system cycle |

## Verification
The bench aims at a read and a write to the same word in one system cycle. A design that commits the write before reading would return the new value there instead of the old one. It drives scrambled inputs during every write phase. A design that samples outside the read-phase edge would either store the scrambled write or change its read outputs mid-cycle. It also issues cycles with the write disabled but a live address and data, where a leaky enable would corrupt a word. Finally, it sends both ports to one address and to different addresses, to catch read multiplexers that share or cross their selects.

// File: rtl/phased_mem_pkg.sv
package phased_mem_pkg;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } phase_e;

    function automatic phase_e phase_advance(input phase_e cur);
        return (cur == PH_READ) ? PH_WRITE : PH_READ;
    endfunction

    function automatic logic is_read_phase(input phase_e cur);
        return cur == PH_READ;
    endfunction

endpackage

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import phased_mem_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_READ;
        else     phase <= phase_advance(phase);
    end

    AST_PHASE_TO_WRITE: assert property (@(posedge clk) disable iff (rst)
        phase == PH_READ |=> phase == PH_WRITE);   // R2
    AST_PHASE_TO_READ: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WRITE |=> phase == PH_READ);   // R2

endmodule

// File: rtl/write_stager.sv
module write_stager
    import phased_mem_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          in_en,
    output logic [AW-1:0] stg_addr,
    output logic [DW-1:0] stg_data,
    output logic          stg_en
);

    logic capture;
    assign capture = is_read_phase(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_addr <= '0;
            stg_data <= '0;
            stg_en   <= 1'b0;
        end else if (capture) begin
            stg_addr <= in_addr;
            stg_data <= in_data;
            stg_en   <= in_en;
        end
    end

    AST_STAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WRITE |=> ($stable(stg_addr) && $stable(stg_data) && $stable(stg_en)));   // R8

endmodule

// File: rtl/shared_array.sv
module shared_array
    import phased_mem_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    input  logic [AW-1:0] w_addr,
    input  logic [DW-1:0] w_data,
    input  logic          w_req,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] cells [WORDS];
    logic          rd_strobe;
    logic          wr_strobe;

    assign rd_strobe = is_read_phase(phase);
    assign wr_strobe = w_req && !is_read_phase(phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_data <= '0;
            rb_data <= '0;
        end else if (rd_strobe) begin
            ra_data <= cells[ra_addr];
            rb_data <= cells[rb_addr];
        end
    end

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[gi] <= '0;
            else if (wr_strobe && w_addr == AW'(gi))
                cells[gi] <= w_data;
        end

        AST_CELL_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            (!w_req || phase == PH_READ || w_addr != AW'(gi)) |=> $stable(cells[gi]));   // R7
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        phase == PH_WRITE |=> ($stable(ra_data) && $stable(rb_data)));   // R4
    AST_SAME_ADDR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ && ra_addr == rb_addr) |=> ra_data == rb_data);   // R9

endmodule

// File: rtl/phased_2r1w_mem.sv
module phased_2r1w_mem
    import phased_mem_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr_a,
    input  logic [AW-1:0] rd_addr_b,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_en,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b,
    output logic          read_phase
);

    phase_e        phase;
    logic [AW-1:0] stg_addr;
    logic [DW-1:0] stg_data;
    logic          stg_en;

    phase_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    write_stager #(.AW(AW), .DW(DW)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .in_addr  (wr_addr),
        .in_data  (wr_data),
        .in_en    (wr_en),
        .stg_addr (stg_addr),
        .stg_data (stg_data),
        .stg_en   (stg_en)
    );

    shared_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .ra_addr (rd_addr_a),
        .rb_addr (rd_addr_b),
        .w_addr  (stg_addr),
        .w_data  (stg_data),
        .w_req   (stg_en),
        .ra_data (rd_data_a),
        .rb_data (rd_data_b)
    );

    assign read_phase = is_read_phase(phase);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (read_phase && rd_data_a == '0 && rd_data_b == '0));   // R1

endmodule

// File: tb/sim_phased_2r1w_mem.sv
`timescale 1ns/1ps
module sim_phased_2r1w_mem;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] rd_data_a, rd_data_b;
    logic          read_phase;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [DW-1:0] model [WORDS];

    always #2.5 clk = ~clk;

    phased_2r1w_mem #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .read_phase(read_phase)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a);
        return model[a];
    endfunction

    // One system cycle; starts and ends at a negedge inside a read phase.
    task automatic sys_cycle(input logic [AW-1:0] ra, input logic [AW-1:0] rb,
                             input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                             input logic we, input string req);
        logic [DW-1:0] ea, eb;
        ea = expect_read(ra);
        eb = expect_read(rb);
        check("R2 read phase", {15'd0, read_phase}, 16'd1);
        rd_addr_a = ra; rd_addr_b = rb; wr_addr = wa; wr_data = wd; wr_en = we;
        @(posedge clk); @(negedge clk);
        check("R2 write phase", {15'd0, read_phase}, 16'd0);
        check({req, " R3 port A"}, rd_data_a, ea);
        check({req, " R3 port B"}, rd_data_b, eb);
        // R8: scramble every input during the write phase
        rd_addr_a = AW'($urandom); rd_addr_b = AW'($urandom);
        wr_addr = AW'($urandom); wr_data = DW'($urandom); wr_en = 1'($urandom);
        @(posedge clk); @(negedge clk);
        check({req, " R4 hold A"}, rd_data_a, ea);
        check({req, " R4 hold B"}, rd_data_b, eb);
        if (we) model[wa] = wd;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 phase", {15'd0, read_phase}, 16'd1);
        check("R1 data A", rd_data_a, '0);
        check("R1 data B", rd_data_b, '0);
        for (int i = 0; i < WORDS; i++)
            sys_cycle(AW'(i), AW'(WORDS - 1 - i), '0, 16'hFFFF, 1'b0, "R1 zero words");
        // R5 write then read back next cycle
        sys_cycle(4'd3, 4'd4, 4'd3, 16'hA5A5, 1'b1, "R5 write");
        sys_cycle(4'd3, 4'd3, 4'd0, 16'h0, 1'b0, "R5 readback R9");
        // R6 same-cycle read of written word returns old data
        sys_cycle(4'd3, 4'd9, 4'd3, 16'h1234, 1'b1, "R6 old data");
        sys_cycle(4'd3, 4'd3, 4'd9, 16'h0BAD, 1'b0, "R6 new visible");
        // R7 disabled write must leave word unchanged
        sys_cycle(4'd7, 4'd9, 4'd9, 16'hDEAD, 1'b0, "R7 disabled");
        sys_cycle(4'd9, 4'd7, 4'd7, 16'hBEEF, 1'b0, "R7 disabled check");
        // R9 both ports same address, written word
        sys_cycle(4'd15, 4'd15, 4'd15, 16'h5A5A, 1'b1, "R9 same");
        sys_cycle(4'd15, 4'd15, 4'd0, 16'h0, 1'b0, "R9 same readback");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] ra, rb, wa;
            ra = AW'($urandom);
            rb = (n % 5 == 0) ? ra : AW'($urandom);
            wa = (n % 4 == 0) ? ra : AW'($urandom);
            sys_cycle(ra, rb, wa, DW'($urandom), 1'($urandom), "R3 random");
        end
        // Final sweep of all words
        for (int i = 0; i < WORDS; i++)
            sys_cycle(AW'(i), AW'(i), '0, '0, 1'b0, "R5 sweep");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule